// File: doc/BRIEF.md
# Streaming Depthwise 3x3 Convolution Stage

This block filters one channel of a feature map with a 3x3 kernel as the pixels stream past, one per accepted cycle, in row-major order. Two line buffers, each one frame width deep, keep the two preceding rows. A 3x3 register window therefore holds every neighbour of the current centre pixel at once. Neighbours that fall outside the frame read as zero, so the border is padded by one pixel on every side.

The nine window values are multiplied by the channel's own nine weights in parallel and added at full width. A bias is then added and the sum is rounded back to Q8.8. A per-channel scale and shift follow, and then one of four activations chosen at run time. One instance handles one channel; a depthwise layer places one instance per channel side by side. A run-time stride select gives either a same-size output frame (stride 1) or a frame decimated by two in both directions (stride 2).

After the last pixel of a frame, the block clocks itself for one row plus one pixel with zero input, which produces the bottom-row results. Input offered during this drain is dropped, so the source leaves at least that many idle cycles between frames. The weights, bias, normalisation and mode inputs are held steady for the whole frame.

Top module: `dw3x3_stage`

## Requirements
- R1: Pixels are signed Q8.8 (16 bits, 8 fraction bits). A frame is IMG_W x IMG_H pixels in row-major order. The pixel taken with `px_sof` high is pixel (0,0), and each later pixel with `px_valid` high is the next one.
- R2: The window sum for centre (r,c) is the sum over dr,dc in {-1,0,1} of weight[3*(dr+1)+(dc+1)] times pixel(r+dr,c+dc). Weight i is `tap_w[16*i+15:16*i]`, so tap 0 is the upper-left neighbour and tap 8 is the lower-right one. Positions outside the frame count as zero.
- R3: The full-precision window sum (Q16.16) plus `bias` shifted left by 8 is rounded by adding 128 and taking the floor after division by 256. The result is then saturated to the range -32768..32767.
- R4: Normalisation forms `norm_scale` times the R3 result plus `norm_shift` shifted left by 8. It rounds and saturates this with the same rule as R3.
- R5: `act_mode` 0 passes the value through. Mode 1 sends negative values to 0. Mode 2 clamps to the range 0..1536 (0.0 to 6.0). Mode 3 takes floor(x/8) for negative x and leaves non-negative x unchanged.
- R6: With `stride2` low, the block gives one result per input pixel, IMG_W*IMG_H per frame, in row-major order of the centres.
- R7: With `stride2` high, the only results are those whose centre has an even row and an even column. That gives ceil(IMG_H/2)*ceil(IMG_W/2) results per frame, in row-major order.
- R8: The result for centre index k appears on `res_valid` 4 cycles after the edge that takes pixel index k+IMG_W+1. The last IMG_W+1 windows come from an internal drain of IMG_W+1 cycles that starts after the frame's final pixel and does not depend on `px_valid`.
- R9: While no frame is in progress, a pixel offered without `px_sof` is ignored and causes no result.
- R10: After reset, `res_valid` and `res_data` are 0.
- R11: Idle cycles on `px_valid` within a frame stall the window without changing any result value or the result order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| px_valid | input | 1 | Pixel present this cycle |
| px_sof | input | 1 | Marks the first pixel of a frame |
| px_data | input | 16 | Pixel value, signed Q8.8 |
| stride2 | input | 1 | 0: stride 1, 1: stride 2 |
| act_mode | input | 2 | Activation select (R5) |
| tap_w | input | 144 | Nine signed Q8.8 weights, tap i in bits 16i+15..16i |
| bias | input | 16 | Signed Q8.8 bias |
| norm_scale | input | 16 | Signed Q8.8 normalisation scale |
| norm_shift | input | 16 | Signed Q8.8 normalisation shift |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 16 | Result value, signed Q8.8 |

## Verification
The bench uses a 6x5 frame so that every result of every frame is compared. An impulse frame with nine distinct weights shows each tap at a separate output. It also places impulses in two corners, so a wrong tap index or a missing border mask cannot hide. Ramp and random frames with odd biases and negative scales separate the two rounding stages. Frames with very large values separate saturation from wrap-around. Each activation mode, both strides and frames with random input bubbles are run. The bench counts results to catch missing or extra drain outputs, and it times the first result against the pixel that completed its window.

// File: rtl/dw3_pkg.sv
package dw3_pkg;
  localparam int Q_W = 16;
  localparam int Q_FB = 8;
  localparam int N_TAPS = 9;
  localparam int LEAK_SH = 3;
  localparam int CLIP_RAW = 6 << Q_FB;
  localparam longint HALF_LSB = longint'(1) <<< (Q_FB - 1);
  localparam longint Q_MAX = (longint'(1) <<< (Q_W - 1)) - 1;
  localparam longint Q_MIN = -(longint'(1) <<< (Q_W - 1));

  typedef logic signed [Q_W-1:0] q_t;

  typedef enum logic [1:0] {
    ACT_PASS  = 2'd0,
    ACT_RELU  = 2'd1,
    ACT_CLIP6 = 2'd2,
    ACT_LEAKY = 2'd3
  } act_e;

  // value carries 2*Q_FB fraction bits; result carries Q_FB
  function automatic q_t round_sat(input longint v);
    longint r;
    r = (v + HALF_LSB) >>> Q_FB;
    if (r > Q_MAX) return q_t'(Q_MAX);
    if (r < Q_MIN) return q_t'(Q_MIN);
    return q_t'(r);
  endfunction

  function automatic q_t act_apply(input act_e m, input q_t x);
    q_t y;
    case (m)
      ACT_RELU:  y = x[Q_W-1] ? '0 : x;
      ACT_CLIP6: begin
        if (x[Q_W-1]) y = '0;
        else if (x > q_t'(CLIP_RAW)) y = q_t'(CLIP_RAW);
        else y = x;
      end
      ACT_LEAKY: y = x[Q_W-1] ? (x >>> LEAK_SH) : x;
      default:   y = x;
    endcase
    return y;
  endfunction
endpackage

// File: rtl/dw3_window.sv
module dw3_window import dw3_pkg::*; #(
  parameter int IMG_W = 32,
  parameter int IMG_H = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       px_valid,
  input  logic                       px_sof,
  input  logic signed [Q_W-1:0]      px_data,
  input  logic                       stride2,
  output logic [N_TAPS*Q_W-1:0]      taps,
  output logic                       win_vld,
  output logic                       adv,
  output logic                       frame_busy,
  output logic [$clog2(IMG_H)-1:0]   cen_row,
  output logic [$clog2(IMG_W)-1:0]   cen_col
);
  localparam int NPIX = IMG_W * IMG_H;
  localparam int LAST = NPIX + IMG_W;
  localparam int KW = $clog2(LAST + 2);
  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H);

  logic [KW-1:0] idx, cur_k;
  logic [CW-1:0] in_col, cur_col, nx_col;
  logic [RW-1:0] nx_row;
  logic draining, take, sof_take, centre_on, centre_first;
  q_t push_pix;

  q_t lb_mid [IMG_W];
  q_t lb_top [IMG_W];
  q_t win [3][3];

  assign draining     = frame_busy && (idx >= KW'(NPIX));
  assign take         = px_valid && !draining && (px_sof || frame_busy);
  assign sof_take     = take && px_sof;
  assign adv          = take || draining;
  assign cur_k        = sof_take ? '0 : idx;
  assign cur_col      = sof_take ? '0 : in_col;
  assign push_pix     = draining ? '0 : px_data;
  assign centre_on    = cur_k >= KW'(IMG_W + 1);
  assign centre_first = cur_k == KW'(IMG_W + 1);

  always_comb begin
    nx_row = cen_row;
    nx_col = cen_col;
    if (centre_first) begin
      nx_row = '0;
      nx_col = '0;
    end else if (cen_col == CW'(IMG_W - 1)) begin
      nx_col = '0;
      nx_row = cen_row + 1'b1;
    end else begin
      nx_col = cen_col + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      in_col     <= '0;
      frame_busy <= 1'b0;
      cen_row    <= '0;
      cen_col    <= '0;
      win_vld    <= 1'b0;
    end else begin
      win_vld <= adv && centre_on && (!stride2 || (!nx_row[0] && !nx_col[0]));
      if (adv) begin
        idx        <= cur_k + 1'b1;
        frame_busy <= cur_k < KW'(LAST);
        in_col     <= (cur_col == CW'(IMG_W - 1)) ? '0 : cur_col + 1'b1;
        if (centre_on) begin
          cen_row <= nx_row;
          cen_col <= nx_col;
        end
      end
    end
  end

  // row storage and window shift: datapath only, no reset needed
  always_ff @(posedge clk) begin
    if (adv) begin
      lb_top[cur_col] <= lb_mid[cur_col];
      lb_mid[cur_col] <= push_pix;
      for (int r = 0; r < 3; r++) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
      end
      win[0][2] <= lb_top[cur_col];
      win[1][2] <= lb_mid[cur_col];
      win[2][2] <= push_pix;
    end
  end

  // zero padding: drop taps that lie outside the frame for this centre
  for (genvar r = 0; r < 3; r++) begin : g_row
    for (genvar c = 0; c < 3; c++) begin : g_col
      logic keep;
      assign keep = (r != 0 || cen_row != '0) &&
                    (r != 2 || cen_row != RW'(IMG_H - 1)) &&
                    (c != 0 || cen_col != '0) &&
                    (c != 2 || cen_col != CW'(IMG_W - 1));
      assign taps[(3*r+c)*Q_W +: Q_W] = keep ? win[r][c] : '0;
    end
  end
endmodule

// File: rtl/dw3_mac.sv
module dw3_mac import dw3_pkg::*; #(
  parameter int ACC_W = 2 * Q_W + 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic [N_TAPS*Q_W-1:0]     taps,
  input  logic [N_TAPS*Q_W-1:0]     coefs,
  output logic signed [ACC_W-1:0]   acc,
  output logic                      acc_vld
);
  localparam int PROD_W = 2 * Q_W;

  logic signed [PROD_W-1:0] prod [N_TAPS];
  logic signed [ACC_W-1:0]  sum;

  for (genvar i = 0; i < N_TAPS; i++) begin : g_mul
    assign prod[i] = $signed(taps[i*Q_W +: Q_W]) * $signed(coefs[i*Q_W +: Q_W]);
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_TAPS; i++) sum = sum + ACC_W'(prod[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      acc_vld <= 1'b0;
    end else begin
      acc_vld <= in_vld;
      if (in_vld) acc <= sum;
    end
  end
endmodule

// File: rtl/dw3_post.sv
module dw3_post import dw3_pkg::*; #(
  parameter int ACC_W = 2 * Q_W + 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic signed [ACC_W-1:0]  acc,
  input  logic signed [Q_W-1:0]    bias,
  input  logic signed [Q_W-1:0]    scale,
  input  logic signed [Q_W-1:0]    shift,
  input  logic [1:0]               act_mode,
  output logic                     out_vld,
  output logic signed [Q_W-1:0]    out_data
);
  q_t   biased, normed;
  logic b_vld, n_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      biased   <= '0;
      normed   <= '0;
      out_data <= '0;
      b_vld    <= 1'b0;
      n_vld    <= 1'b0;
      out_vld  <= 1'b0;
    end else begin
      b_vld   <= in_vld;
      n_vld   <= b_vld;
      out_vld <= n_vld;
      if (in_vld)
        biased <= round_sat(longint'(acc) + (longint'(bias) <<< Q_FB));
      if (b_vld)
        normed <= round_sat(longint'(scale) * longint'(biased) + (longint'(shift) <<< Q_FB));
      if (n_vld)
        out_data <= act_apply(act_e'(act_mode), normed);
    end
  end
endmodule

// File: rtl/dw3x3_stage.sv
module dw3x3_stage import dw3_pkg::*; #(
  parameter int IMG_W = 32,
  parameter int IMG_H = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       px_valid,
  input  logic                       px_sof,
  input  logic signed [Q_W-1:0]      px_data,
  input  logic                       stride2,
  input  logic [1:0]                 act_mode,
  input  logic [N_TAPS*Q_W-1:0]      tap_w,
  input  logic signed [Q_W-1:0]      bias,
  input  logic signed [Q_W-1:0]      norm_scale,
  input  logic signed [Q_W-1:0]      norm_shift,
  output logic                       res_valid,
  output logic signed [Q_W-1:0]      res_data
);
  localparam int ACC_W = 2 * Q_W + $clog2(N_TAPS) + 1;

  logic [N_TAPS*Q_W-1:0]     taps;
  logic                      win_vld, adv, frame_busy, mac_vld;
  logic [$clog2(IMG_H)-1:0]  cen_row;
  logic [$clog2(IMG_W)-1:0]  cen_col;
  logic signed [ACC_W-1:0]   acc;

  dw3_window #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_win (
    .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_sof(px_sof),
    .px_data(px_data), .stride2(stride2), .taps(taps), .win_vld(win_vld),
    .adv(adv), .frame_busy(frame_busy), .cen_row(cen_row), .cen_col(cen_col)
  );

  dw3_mac #(.ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .in_vld(win_vld), .taps(taps), .coefs(tap_w),
    .acc(acc), .acc_vld(mac_vld)
  );

  dw3_post #(.ACC_W(ACC_W)) u_post (
    .clk(clk), .rst_n(rst_n), .in_vld(mac_vld), .acc(acc), .bias(bias),
    .scale(norm_scale), .shift(norm_shift), .act_mode(act_mode),
    .out_vld(res_valid), .out_data(res_data)
  );
endmodule

// File: rtl/dw3_checker.sv
module dw3_checker import dw3_pkg::*; #(
  parameter int IMG_W = 32,
  parameter int IMG_H = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      stride2,
  input logic [1:0]                act_mode,
  input logic                      res_valid,
  input logic signed [Q_W-1:0]     res_data,
  input logic                      win_vld,
  input logic                      frame_busy,
  input logic [$clog2(IMG_H)-1:0]  cen_row,
  input logic [$clog2(IMG_W)-1:0]  cen_col
);
  // R8: every completed window leaves the pipeline exactly four cycles later
  p_latency_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> ##4 res_valid);

  // R8: no result without a window four cycles earlier
  p_latency_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(win_vld, 4));

  // R5: rectifier output is never negative
  p_relu_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(act_mode) == 2'(ACT_RELU)) |-> !res_data[Q_W-1]);

  // R5: clamp mode stays within 0.0..6.0
  p_clip_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(act_mode) == 2'(ACT_CLIP6)) |->
      (!res_data[Q_W-1] && res_data <= $signed(Q_W'(CLIP_RAW))));

  // R7: decimated windows sit on even rows and even columns
  p_stride_grid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && $past(stride2)) |-> (!cen_row[0] && !cen_col[0]));

  // R9: a window only completes while a frame is in progress
  p_frame_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> $past(frame_busy));
endmodule

bind dw3x3_stage dw3_checker #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk(clk), .rst_n(rst_n), .stride2(stride2), .act_mode(act_mode),
  .res_valid(res_valid), .res_data(res_data), .win_vld(win_vld),
  .frame_busy(frame_busy), .cen_row(cen_row), .cen_col(cen_col)
);

// File: tb/sim_dw3x3_stage.sv
`timescale 1ns/100ps
module sim_dw3x3_stage;
  localparam int TW = 6;
  localparam int TH = 5;
  localparam int NP = TW * TH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic px_valid = 1'b0, px_sof = 1'b0, stride2 = 1'b0;
  logic signed [15:0] px_data = '0, bias = '0, norm_scale = '0, norm_shift = '0;
  logic [1:0] act_mode = '0;
  logic [143:0] tap_w = '0;
  logic res_valid;
  logic signed [15:0] res_data;

  dw3x3_stage #(.IMG_W(TW), .IMG_H(TH)) u0 (
    .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_sof(px_sof),
    .px_data(px_data), .stride2(stride2), .act_mode(act_mode), .tap_w(tap_w),
    .bias(bias), .norm_scale(norm_scale), .norm_shift(norm_shift),
    .res_valid(res_valid), .res_data(res_data)
  );

  always #2.5 clk = ~clk;

  int img [NP];
  int wt [9];
  int got [NP];
  int n_got = 0;
  int checks = 0, fails = 0;
  int edge_n = 0, in_edge = -1, first_edge = -1, drv_k = -1;
  bit done = 1'b0;

  always @(posedge clk) begin
    edge_n <= edge_n + 1;
    if (px_valid && drv_k == TW + 1) in_edge <= edge_n + 1;
  end

  always @(negedge clk) begin
    if (res_valid) begin
      if (first_edge < 0) first_edge = edge_n;
      if (n_got < NP) got[n_got] = int'(res_data);
      n_got++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", tag, act, exp);
    end
  endtask

  function automatic longint fdiv(input longint v, input longint d);
    longint q;
    q = v / d;
    if ((v % d) != 0 && ((v < 0) != (d < 0))) q = q - 1;
    return q;
  endfunction

  function automatic int rs(input longint v);
    longint q;
    q = fdiv(v + 128, 256);
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  function automatic int model(input int r, input int c);
    longint acc = 0;
    int s1, s2;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        if (r + dr >= 0 && r + dr < TH && c + dc >= 0 && c + dc < TW)
          acc += longint'(wt[(dr + 1) * 3 + dc + 1]) * img[(r + dr) * TW + c + dc];
    s1 = rs(acc + longint'(int'(bias)) * 256);
    s2 = rs(longint'(int'(norm_scale)) * s1 + longint'(int'(norm_shift)) * 256);
    case (act_mode)
      2'd1: return (s2 < 0) ? 0 : s2;
      2'd2: return (s2 < 0) ? 0 : ((s2 > 1536) ? 1536 : s2);
      2'd3: return (s2 < 0) ? int'(fdiv(s2, 8)) : s2;
      default: return s2;
    endcase
  endfunction

  task automatic rand_img(input int span);
    for (int k = 0; k < NP; k++) img[k] = int'($urandom % (2 * span + 1)) - span;
  endtask

  task automatic rand_wts(input int span);
    for (int i = 0; i < 9; i++) wt[i] = int'($urandom % (2 * span + 1)) - span;
  endtask

  task automatic run_frame(input string tag, input bit bub, input bit do_lat);
    int i;
    for (int t = 0; t < 9; t++) tap_w[t*16 +: 16] = 16'(wt[t]);
    @(negedge clk);
    n_got = 0;
    first_edge = -1;
    in_edge = -1;
    for (int k = 0; k < NP; k++) begin
      while (bub && ($urandom % 3 == 0)) begin
        px_valid = 1'b0;
        px_sof = 1'b0;
        drv_k = -1;
        @(negedge clk);
      end
      px_valid = 1'b1;
      px_sof = (k == 0);
      px_data = 16'(img[k]);
      drv_k = k;
      @(negedge clk);
    end
    px_valid = 1'b0;
    px_sof = 1'b0;
    drv_k = -1;
    repeat (TW + 14) @(negedge clk);
    i = 0;
    for (int r = 0; r < TH; r++)
      for (int c = 0; c < TW; c++)
        if (!stride2 || (r % 2 == 0 && c % 2 == 0)) begin
          if (i < NP) chk(got[i] == model(r, c), tag, got[i], model(r, c));
          i++;
        end
    chk(n_got == i, stride2 ? "R7 result count" : "R6/R8 result count incl. drain", n_got, i);
    if (do_lat) chk(first_edge == in_edge + 4, "R8 first-result latency", first_edge - in_edge, 4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog got hung exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk(res_valid == 1'b0, "R10 reset valid", int'(res_valid), 0);
    chk(res_data == 16'sd0, "R10 reset data", int'(res_data), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: pixels without start-of-frame while idle
    n_got = 0;
    px_valid = 1'b1;
    px_data = 16'sd300;
    repeat (8) @(negedge clk);
    px_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_got == 0, "R9 stray pixels ignored", n_got, 0);

    // R1 R2: impulses in two corners and inside, distinct weights
    for (int k = 0; k < NP; k++) img[k] = 0;
    img[0] = 256;
    img[NP - 1] = 512;
    img[2 * TW + 3] = -256;
    for (int t = 0; t < 9; t++) wt[t] = (t + 1) * 32;
    bias = 16'sd0; norm_scale = 16'sd256; norm_shift = 16'sd0;
    act_mode = 2'd0; stride2 = 1'b0;
    run_frame("R2 tap order and padding", 1'b0, 1'b1);

    // R3: ramp with odd bias, exercises rounding
    for (int k = 0; k < NP; k++) img[k] = k * 37 - 500;
    rand_wts(300);
    bias = 16'sd77;
    run_frame("R3 bias and rounding", 1'b0, 1'b1);

    // R4: negative scale with shift
    rand_img(512); rand_wts(256);
    bias = -16'sd40; norm_scale = -16'sd384; norm_shift = 16'sd300;
    run_frame("R4 normalisation", 1'b0, 1'b0);

    // R5: the three non-trivial activations (relu frame with bubbles, R11)
    rand_img(512); rand_wts(256);
    bias = 16'sd10; norm_scale = 16'sd256; norm_shift = -16'sd50;
    act_mode = 2'd1;
    run_frame("R5 relu", 1'b1, 1'b1);
    rand_img(512); rand_wts(256);
    norm_scale = 16'sd768; act_mode = 2'd2;
    run_frame("R5 clip6", 1'b0, 1'b0);
    rand_img(512); rand_wts(256);
    norm_scale = 16'sd200; act_mode = 2'd3;
    run_frame("R5 leaky", 1'b0, 1'b0);

    // R3: saturation on both rails
    rand_img(30000); rand_wts(20000);
    bias = 16'sd0; norm_scale = 16'sd256; norm_shift = 16'sd0; act_mode = 2'd0;
    run_frame("R3 saturation", 1'b0, 1'b0);

    // R7: stride 2 with bubbles
    rand_img(512); rand_wts(256);
    bias = -16'sd3; norm_scale = 16'sd256; stride2 = 1'b1;
    run_frame("R7 stride2", 1'b1, 1'b1);

    // R11: stride 1 with bubbles, R6 ordering
    rand_img(512); rand_wts(256);
    stride2 = 1'b0; norm_scale = -16'sd256;
    run_frame("R11 bubbles", 1'b1, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule